// File: doc/BRIEF.md
# Fractional-Ratio PWM Timebase

This block generates the shared time reference for a bank of PWM channels. It takes a source that advances either on every cycle of the fast clock or only on cycles where a slow reference pulse is present. It divides that source by a ratio held in unsigned fixed point with 8 fractional bits. The divided ticks drive a counter whose period is a power of two chosen at run time, from 2^0 up to 2^20. Channels compare the count against their own thresholds. They use the tick pulse to know when the count moved and the wrap pulse to know when a period began.

Non-integer ratios work by carrying the remainder between ticks. An accumulator gains 256 for each source cycle. A tick is issued, and the ratio is subtracted, once the sum reaches the ratio. The average tick rate is exact. Individual tick spacings differ by at most one source cycle.

Ratio and width changes are staged. The update strobe loads them into a shadow copy, and the shadow takes effect on the next counter wrap, so a running period is never shortened. While the clear input is held, a staged setting takes effect at once. All inputs are plain control pins with no handshake, because no data stream enters or leaves the block.

Top module: `pwm_timebase`

## Requirements
- R1: After reset the count is 0, and neither tick_o nor wrap_o is asserted.
- R2: With ratio 256 (1.0) and the fast source, tick_o is high on every cycle, and the count advances by one on every cycle.
- R3: With ratio D, n source cycles counted from a cleared accumulator yield exactly floor(n*256/D) ticks. For D=640, 50 cycles yield 20 ticks. For D=384, ticks follow a pattern of two in every three cycles.
- R4: Each tick_o cycle shows the count one above its previous value. From 2^W-1 the count instead goes to 0, and wrap_o is high in that same single cycle.
- R5: With width 0 the count stays at 0, and wrap_o is asserted with every tick.
- R6: While cfg_pause is 1 (and cfg_clear is 0), the count and the accumulator hold, and no tick is produced.
- R7: While cfg_clear is 1, the count and the accumulator are forced to 0 with no tick, and a staged setting is applied. Counting resumes once cfg_clear returns to 0.
- R8: A cfg_update pulse captures cfg_div and cfg_width. They take effect only after the next wrap of the current period.
- R9: A ratio below 256 is treated as 256. It leaves no residue in the accumulator, so a later larger ratio starts from a clean remainder.
- R10: With cfg_src_sel=1, only cycles with ref_pulse=1 feed the divider. With cfg_src_sel=0, every clock cycle does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_pulse | input | 1 | One-cycle marker of the slow reference, synchronous to clk |
| cfg_div | input | 18 | Division ratio, unsigned 10.8 fixed point |
| cfg_width | input | 5 | Counter width W; the period is 2^W ticks (values above 20 act as 20) |
| cfg_src_sel | input | 1 | 0 = every clock cycle, 1 = reference pulses only |
| cfg_pause | input | 1 | Freeze the counter and the divider |
| cfg_clear | input | 1 | Hold the counter and the divider at zero |
| cfg_update | input | 1 | Stage cfg_div and cfg_width for the next wrap |
| cnt_o | output | 20 | Current count |
| tick_o | output | 1 | High in the cycle the count has just advanced |
| wrap_o | output | 1 | High in the cycle the count has just returned to 0 |

## Verification
The divider is driven with ratio 1.0, 1.5, 2.5 and 2.0, and with a sub-unity value. This separates an exact every-cycle tick from the two-in-three and two-in-five spacing of fractional remainders. It also shows whether an unclamped ratio leaves residue that skews the next setting. Widths 3, 2 and 0 show where the wrap lands, including the degenerate single-value period. A settings update issued mid-period shows whether the new width waits for the wrap. Pause, clear and the sparse reference source are each placed in the middle of a count, which tells holding apart from resetting and from skipped source cycles.

// File: rtl/pwm_timebase_pkg.sv
package pwm_timebase_pkg;
  localparam int CNT_W  = 20;
  localparam int DIV_W  = 18;
  localparam int WID_W  = 5;
  localparam int FRAC_W = 8;
  localparam int ACC_W  = DIV_W + 1;
  localparam logic [DIV_W-1:0] UNITY = DIV_W'(1) << FRAC_W;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic [WID_W-1:0] width;
  } tb_cfg_t;
endpackage

// File: rtl/pwm_src_gate.sv
module pwm_src_gate (
  input  logic sel,
  input  logic ref_pulse,
  input  logic pause,
  input  logic clear,
  output logic step_en
);
  logic src;
  always_comb begin
    src     = sel ? ref_pulse : 1'b1;
    step_en = src && !pause && !clear;
  end
endmodule

// File: rtl/pwm_cfg_stage.sv
module pwm_cfg_stage
  import pwm_timebase_pkg::*;
#(
  parameter bit               STAGED    = 1'b1,
  parameter logic [DIV_W-1:0] RST_DIV   = UNITY,
  parameter logic [WID_W-1:0] RST_WIDTH = 5'd4
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    update,
  input  tb_cfg_t cfg_in,
  input  logic    apply,
  output tb_cfg_t active
);
  generate
    if (STAGED) begin : g_staged
      tb_cfg_t shadow_q, active_q;
      logic    pending_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          shadow_q  <= '{div: RST_DIV, width: RST_WIDTH};
          active_q  <= '{div: RST_DIV, width: RST_WIDTH};
          pending_q <= 1'b0;
        end else begin
          if (apply && pending_q) active_q <= shadow_q;
          if (update) begin
            shadow_q  <= cfg_in;
            pending_q <= 1'b1;
          end else if (apply) begin
            pending_q <= 1'b0;
          end
        end
      end
      assign active = active_q;
    end else begin : g_direct
      assign active = cfg_in;
    end
  endgenerate
endmodule

// File: rtl/pwm_frac_div.sv
module pwm_frac_div
  import pwm_timebase_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_en,
  input  logic             clear,
  input  logic [DIV_W-1:0] div,
  output logic             hit
);
  logic [ACC_W-1:0] acc_q, sum, div_eff;

  always_comb begin
    div_eff = (div < UNITY) ? ACC_W'(UNITY) : ACC_W'(div);
    sum     = acc_q + ACC_W'(UNITY);
    hit     = step_en && (sum >= div_eff);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       acc_q <= '0;
    else if (clear)   acc_q <= '0;
    else if (step_en) acc_q <= hit ? (sum - div_eff) : sum;
  end
endmodule

// File: rtl/pwm_wrap_cnt.sv
module pwm_wrap_cnt
  import pwm_timebase_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             adv,
  input  logic [WID_W-1:0] width,
  output logic             wrap_next,
  output logic [CNT_W-1:0] cnt_o,
  output logic             tick_o,
  output logic             wrap_o
);
  logic [WID_W-1:0] w_eff;
  logic [CNT_W:0]   lim;
  logic [CNT_W-1:0] top_val;

  always_comb begin
    w_eff     = (width > WID_W'(CNT_W)) ? WID_W'(CNT_W) : width;
    lim       = ((CNT_W+1)'(1) << w_eff) - (CNT_W+1)'(1);
    top_val   = lim[CNT_W-1:0];
    wrap_next = adv && (cnt_o >= top_val);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_o  <= '0;
      tick_o <= 1'b0;
      wrap_o <= 1'b0;
    end else begin
      tick_o <= adv && !clear;
      wrap_o <= wrap_next && !clear;
      if (clear)          cnt_o <= '0;
      else if (wrap_next) cnt_o <= '0;
      else if (adv)       cnt_o <= cnt_o + CNT_W'(1);
    end
  end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_timebase_pkg::*;
#(
  parameter bit STAGED = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_pulse,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [WID_W-1:0] cfg_width,
  input  logic             cfg_src_sel,
  input  logic             cfg_pause,
  input  logic             cfg_clear,
  input  logic             cfg_update,
  output logic [CNT_W-1:0] cnt_o,
  output logic             tick_o,
  output logic             wrap_o
);
  logic    step_en, hit, wrap_next, apply;
  tb_cfg_t cfg_in, active;

  assign cfg_in = '{div: cfg_div, width: cfg_width};
  assign apply  = cfg_clear || wrap_next;

  pwm_src_gate u_gate (
    .sel(cfg_src_sel), .ref_pulse(ref_pulse), .pause(cfg_pause),
    .clear(cfg_clear), .step_en(step_en)
  );

  pwm_cfg_stage #(.STAGED(STAGED)) u_stage (
    .clk(clk), .rst_n(rst_n), .update(cfg_update), .cfg_in(cfg_in),
    .apply(apply), .active(active)
  );

  pwm_frac_div u_div (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .clear(cfg_clear),
    .div(active.div), .hit(hit)
  );

  pwm_wrap_cnt u_cnt (
    .clk(clk), .rst_n(rst_n), .clear(cfg_clear), .adv(hit),
    .width(active.width), .wrap_next(wrap_next),
    .cnt_o(cnt_o), .tick_o(tick_o), .wrap_o(wrap_o)
  );
endmodule

// File: rtl/pwm_timebase_chk.sv
module pwm_timebase_chk
  import pwm_timebase_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             ref_pulse,
  input logic             cfg_src_sel,
  input logic             cfg_pause,
  input logic             cfg_clear,
  input logic [DIV_W-1:0] act_div,
  input logic [CNT_W-1:0] cnt_o,
  input logic             tick_o,
  input logic             wrap_o
);
  AST_WRAP_WITH_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |-> (tick_o && cnt_o == '0)); // R4
  AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && !wrap_o) |-> (cnt_o == $past(cnt_o) + CNT_W'(1))); // R4
  AST_PAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_pause && !cfg_clear) |=> (!tick_o && cnt_o == $past(cnt_o))); // R6
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_clear |=> (cnt_o == '0 && !tick_o && !wrap_o)); // R7
  AST_REF_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_src_sel && !ref_pulse) |=> !tick_o); // R10
  AST_UNITY_RATE: assert property (@(posedge clk) disable iff (!rst_n)
    (act_div <= UNITY && !cfg_src_sel && !cfg_pause && !cfg_clear) |=> tick_o); // R2
  AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (act_div != $past(act_div)) |-> (wrap_o || $past(cfg_clear))); // R8
endmodule

bind pwm_timebase pwm_timebase_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .cfg_src_sel(cfg_src_sel),
  .cfg_pause(cfg_pause), .cfg_clear(cfg_clear), .act_div(active.div),
  .cnt_o(cnt_o), .tick_o(tick_o), .wrap_o(wrap_o)
);

// File: tb/pwm_timebase_test.sv
`timescale 1ns/1ps
module pwm_timebase_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_pulse = 1'b0;
  logic [17:0] cfg_div = 18'd256;
  logic [4:0]  cfg_width = 5'd4;
  logic        cfg_src_sel = 1'b0, cfg_pause = 1'b0, cfg_clear = 1'b0, cfg_update = 1'b0;
  logic [19:0] cnt_o;
  logic        tick_o, wrap_o;

  int checks = 0;
  int errors = 0;
  int tick_seen = 0;

  typedef struct { int cnt; bit tick; bit wrap; string tag; } exp_t;
  exp_t sb[$];

  // model state taken from the requirements
  int  m_acc = 0, m_cnt = 0, m_adiv = 256, m_aw = 4, m_sdiv = 256, m_sw = 4;
  bit  m_pend = 0;

  always #2.5 clk = ~clk;

  pwm_timebase uut (
    .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .cfg_div(cfg_div),
    .cfg_width(cfg_width), .cfg_src_sel(cfg_src_sel), .cfg_pause(cfg_pause),
    .cfg_clear(cfg_clear), .cfg_update(cfg_update), .cnt_o(cnt_o),
    .tick_o(tick_o), .wrap_o(wrap_o)
  );

  task automatic step(input bit sel, input bit rp, input bit pau, input bit clr,
                      input bit upd, input int dv, input int w, input string tag);
    exp_t e;
    int   d, top, sum;
    bit   apply;
    cfg_src_sel = sel; ref_pulse = rp; cfg_pause = pau; cfg_clear = clr;
    cfg_update = upd; cfg_div = 18'(dv); cfg_width = 5'(w);
    d   = (m_adiv < 256) ? 256 : m_adiv;
    top = (1 << ((m_aw > 20) ? 20 : m_aw)) - 1;
    e.tick = 0; e.wrap = 0; e.tag = tag; apply = 0;
    if (clr) begin
      m_acc = 0; m_cnt = 0; apply = 1;
    end else if (!pau && (!sel || rp)) begin
      sum = m_acc + 256;
      if (sum >= d) begin
        m_acc = sum - d; e.tick = 1;
        if (m_cnt >= top) begin m_cnt = 0; e.wrap = 1; apply = 1; end
        else m_cnt++;
      end else m_acc = sum;
    end
    if (apply && m_pend) begin m_adiv = m_sdiv; m_aw = m_sw; end
    if (upd) begin m_sdiv = dv; m_sw = w; m_pend = 1; end
    else if (apply) m_pend = 0;
    e.cnt = m_cnt;
    sb.push_back(e);
    @(negedge clk);
  endtask

  task automatic run(input int n, input bit sel, input int ref_every, input string tag);
    for (int i = 0; i < n; i++)
      step(sel, (ref_every > 0) && (i % ref_every == 0), 0, 0, 0, cfg_div, cfg_width, tag);
  endtask

  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (tick_o) tick_seen++;
      if (cnt_o != 20'(e.cnt) || tick_o != e.tick || wrap_o != e.wrap) begin
        errors++;
        $display("FAIL %s cnt/tick/wrap actual %0d/%0d/%0d expected %0d/%0d/%0d",
                 e.tag, cnt_o, tick_o, wrap_o, e.cnt, e.tick, e.wrap);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    checks++; // R1 reset state
    if (cnt_o != 0 || tick_o || wrap_o) begin
      errors++;
      $display("FAIL R1 cnt/tick/wrap actual %0d/%0d/%0d expected 0/0/0", cnt_o, tick_o, wrap_o);
    end
    // R7: stage ratio 1.0 width 3 under clear, applied on the second clear cycle
    step(0, 0, 0, 1, 1, 256, 3, "R7");
    step(0, 0, 0, 1, 0, 256, 3, "R7");
    run(20, 0, 0, "R2");                      // R2 and R4: wraps after 7
    // R8 and R9: stage sub-unity ratio with width 2 mid-period
    step(0, 0, 0, 0, 1, 100, 2, "R8");
    run(12, 0, 0, "R8");
    step(0, 0, 0, 0, 1, 512, 2, "R9");        // next wrap loads ratio 2.0
    run(14, 0, 0, "R9");
    for (int i = 0; i < 5; i++) step(0, 0, 1, 0, 0, 512, 2, "R6");
    run(6, 0, 0, "R6");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 0, 512, 2, "R7");
    run(6, 0, 0, "R7");
    run(24, 1, 3, "R10");                     // sparse reference source
    run(6, 1, 0, "R10");                      // no reference pulses at all
    step(0, 0, 0, 1, 1, 256, 0, "R5");
    step(0, 0, 0, 1, 0, 256, 0, "R5");
    run(8, 0, 0, "R5");
    step(0, 0, 0, 1, 1, 384, 3, "R3");
    step(0, 0, 0, 1, 0, 384, 3, "R3");
    run(30, 0, 0, "R3");
    step(0, 0, 0, 1, 1, 640, 6, "R3");
    step(0, 0, 0, 1, 0, 640, 6, "R3");
    tick_seen = 0;
    run(50, 0, 0, "R3");
    checks++; // R3 average rate for ratio 2.5
    if (tick_seen != 20) begin
      errors++;
      $display("FAIL R3 ticks in 50 cycles actual %0d expected 20", tick_seen);
    end
    @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule